// File: doc/BRIEF.md
# Saturating doubling multiply unit

This block multiplies signed lanes pairwise and returns twice the product of each pair. The lanes are either 16 or 32 bits wide. A two-bit mode input selects one of three result forms. The first is the upper half of the doubled product, truncated. The second is the same upper half, rounded to nearest by adding half of one output step before the shift. The third is a long form that returns the whole doubled product in a lane twice the source width.

Only one operand pair overflows the doubled product: both lanes holding the most negative value. For that pair the lane is clamped to the most positive value that its output width can hold. A sticky saturation flag is then set and stays set until software-side logic pulses a synchronous clear.

The `full_i` input has one meaning in the high-half forms and another in the long form. In the high-half forms it chooses between a 64-bit and a 128-bit operand vector. In the long form it chooses which 64-bit half of the operands is widened into the 128-bit result. Results and the flag are registered and appear one cycle after `valid_i`.

Top module: `sdm_unit`

## Requirements
- R1: With `mode_i` = 2'b00, each active lane k of width N (N = 16 when `wide_i` = 0, 32 when `wide_i` = 1) returns bits [2N-1:N] of 2·a·b, where a and b are the signed lanes at bits [kN+N-1:kN] of `a_i` and `b_i`. The result is placed at the same bit position of `res_o`.
- R2: With `mode_i` = 2'b01, each active lane returns bits [2N-1:N] of 2·a·b + 2^(N-1).
- R3: With `mode_i` = 2'b10, source lane k of the selected 64-bit half produces the full 2N-bit value 2·a·b at bits [2Nk+2N-1:2Nk] of `res_o`. With 16-bit sources this gives four 32-bit results; with 32-bit sources it gives two 64-bit results. `full_i` = 0 selects operand bits [63:0], and `full_i` = 1 selects bits [127:64].
- R4: When both lanes of a pair equal the most negative N-bit value, the result lane is the most positive value of the output lane width. That is 0x7FFF or 0x7FFFFFFF in the high-half forms, and 0x7FFFFFFF or 0x7FFFFFFFFFFFFFFF in the long form. The clamp also sets the flag.
- R5: `sat_o` goes high on the cycle after any active lane of a valid operation clamps. It then stays high until it is cleared.
- R6: `sat_clr_i` clears `sat_o` on the next edge. A clamp accepted on the same edge as a clear wins, and `sat_o` stays high.
- R7: In the high-half forms with `full_i` = 0, only operand bits [63:0] are used, and `res_o[127:64]` is zero.
- R8: `mode_i` = 2'b11 is reserved. It yields an all-zero result and leaves `sat_o` unchanged.
- R9: `valid_o` follows `valid_i` with one cycle of latency. While `valid_i` is low, `res_o` holds its last value and `sat_o` is not set.
- R10: During reset `res_o`, `valid_o` and `sat_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands valid this cycle |
| mode_i | input | 2 | 00 high, 01 rounding high, 10 long, 11 reserved |
| wide_i | input | 1 | Lane width: 0 = 16-bit, 1 = 32-bit |
| full_i | input | 1 | High forms: 128-bit vector; long form: take upper source half |
| a_i | input | 128 | First operand vector |
| b_i | input | 128 | Second operand vector |
| sat_clr_i | input | 1 | Synchronous clear of the sticky flag |
| valid_o | output | 1 | Result valid |
| res_o | output | 128 | Registered result vector |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The clamp fires only when both operands of one lane hold the most negative value. Random data almost never produces this. The stimulus therefore patches that value into a chosen lane of both operands in about a quarter of the random operations, in every mode, width and half. The lane is picked at random and is sometimes an inactive lane, which must not raise the flag.

Directed steps cover the harder timing cases. One places a clear on the same edge as a clamp. Another issues a reserved-mode operation while the flag is already set. A third starts a clamp while `valid_i` is low.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int W16 = 16;
  localparam int W32 = 32;

  typedef enum logic [1:0] {
    MODE_HI   = 2'b00,
    MODE_RHI  = 2'b01,
    MODE_LONG = 2'b10,
    MODE_RSVD = 2'b11
  } sdm_mode_e;
endpackage

// File: rtl/sdm_lane.sv
module sdm_lane #(
  parameter int N = 16
) (
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [N-1:0]   hi_o,
  output logic [N-1:0]   rhi_o,
  output logic [2*N-1:0] lng_o,
  output logic           ovf_o
);
  localparam logic [N-1:0]   MIN_N = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0]   MAX_N = ~MIN_N;
  localparam logic [2*N-1:0] MAX_L = {1'b0, {(2*N-1){1'b1}}};

  logic signed [2*N-1:0] prod;
  logic [2*N-1:0] dbl;
  logic [N-1:0]   rnd_hi;

  assign prod   = $signed({{N{a_i[N-1]}}, a_i}) * $signed({{N{b_i[N-1]}}, b_i});
  assign dbl    = prod << 1;
  // rounding constant only carries into the high half through bit N-1
  assign rnd_hi = dbl[2*N-1:N] + {{(N-1){1'b0}}, dbl[N-1]};
  assign ovf_o  = (a_i == MIN_N) && (b_i == MIN_N);

  assign hi_o  = ovf_o ? MAX_N : dbl[2*N-1:N];
  assign rhi_o = ovf_o ? MAX_N : rnd_hi;
  assign lng_o = ovf_o ? MAX_L : dbl;
endmodule

// File: rtl/sdm_sticky.sv
module sdm_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !clr_i |=> flag_o); // R5
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !flag_o); // R6
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o); // R6
endmodule

// File: rtl/sdm_unit.sv
module sdm_unit
  import sdm_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       mode_i,
  input  logic             wide_i,
  input  logic             full_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic             sat_clr_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] res_o,
  output logic             sat_o
);
  localparam int L16 = VEC_W / W16;
  localparam int L32 = VEC_W / W32;
  localparam int H16 = L16 / 2;
  localparam int H32 = L32 / 2;

  sdm_mode_e mode;
  logic      long_mode;
  assign mode      = sdm_mode_e'(mode_i);
  assign long_mode = (mode == MODE_LONG);

  logic [W16-1:0]   hi16  [L16];
  logic [W16-1:0]   rhi16 [L16];
  logic [2*W16-1:0] lng16 [L16];
  logic [L16-1:0]   ovf16, act16;
  logic [W32-1:0]   hi32  [L32];
  logic [W32-1:0]   rhi32 [L32];
  logic [2*W32-1:0] lng32 [L32];
  logic [L32-1:0]   ovf32, act32;

  logic [VEC_W-1:0] hi16_v, rhi16_v, lng16_v;
  logic [VEC_W-1:0] hi32_v, rhi32_v, lng32_v;

  for (genvar i = 0; i < L16; i++) begin : g_l16
    sdm_lane #(.N(W16)) u_lane (
      .a_i  (a_i[i*W16 +: W16]),
      .b_i  (b_i[i*W16 +: W16]),
      .hi_o (hi16[i]),
      .rhi_o(rhi16[i]),
      .lng_o(lng16[i]),
      .ovf_o(ovf16[i])
    );
    if (i >= H16) begin : g_up
      assign act16[i] = full_i;
    end else begin : g_lo
      assign act16[i] = long_mode ? !full_i : 1'b1;
    end
    assign hi16_v[i*W16 +: W16]  = act16[i] ? hi16[i]  : '0;
    assign rhi16_v[i*W16 +: W16] = act16[i] ? rhi16[i] : '0;
  end

  for (genvar j = 0; j < H16; j++) begin : g_w16
    assign lng16_v[j*2*W16 +: 2*W16] = full_i ? lng16[j+H16] : lng16[j];
  end

  for (genvar i = 0; i < L32; i++) begin : g_l32
    sdm_lane #(.N(W32)) u_lane (
      .a_i  (a_i[i*W32 +: W32]),
      .b_i  (b_i[i*W32 +: W32]),
      .hi_o (hi32[i]),
      .rhi_o(rhi32[i]),
      .lng_o(lng32[i]),
      .ovf_o(ovf32[i])
    );
    if (i >= H32) begin : g_up
      assign act32[i] = full_i;
    end else begin : g_lo
      assign act32[i] = long_mode ? !full_i : 1'b1;
    end
    assign hi32_v[i*W32 +: W32]  = act32[i] ? hi32[i]  : '0;
    assign rhi32_v[i*W32 +: W32] = act32[i] ? rhi32[i] : '0;
  end

  for (genvar j = 0; j < H32; j++) begin : g_w32
    assign lng32_v[j*2*W32 +: 2*W32] = full_i ? lng32[j+H32] : lng32[j];
  end

  logic [VEC_W-1:0] res_d;
  logic             sat_hit;

  always_comb begin
    unique case (mode)
      MODE_HI:   res_d = wide_i ? hi32_v  : hi16_v;
      MODE_RHI:  res_d = wide_i ? rhi32_v : rhi16_v;
      MODE_LONG: res_d = wide_i ? lng32_v : lng16_v;
      default:   res_d = '0;
    endcase
  end

  assign sat_hit = valid_i && (mode != MODE_RSVD) &&
                   (wide_i ? |(ovf32 & act32) : |(ovf16 & act16));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= res_d;
    end
  end

  sdm_sticky u_sticky (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (sat_clr_i),
    .set_i (sat_hit),
    .flag_o(sat_o)
  );

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o)); // R9
  AST_IDLE_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !sat_o |=> !sat_o); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (mode_i == 2'b11) |=> res_o == '0); // R8
  AST_RSVD_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (mode_i == 2'b11) && !sat_o |=> !sat_o); // R8
endmodule

// File: tb/sdm_unit_test.sv
module sdm_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 128;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          valid_i;
  logic [1:0]    mode_i;
  logic          wide_i;
  logic          full_i;
  logic [VW-1:0] a_i, b_i;
  logic          sat_clr_i;
  logic          valid_o;
  logic [VW-1:0] res_o;
  logic          sat_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [VW-1:0] exp_res;
  logic          exp_valid;
  logic          exp_sat;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdm_unit #(.VEC_W(VW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .wide_i(wide_i), .full_i(full_i), .a_i(a_i), .b_i(b_i),
    .sat_clr_i(sat_clr_i), .valid_o(valid_o), .res_o(res_o), .sat_o(sat_o)
  );

  function automatic logic signed [65:0] lane_val(input logic [127:0] v, input int n, input int k);
    logic [127:0] t;
    logic signed [65:0] x;
    t = (v >> (k*n)) & ((128'd1 << n) - 1);
    x = 66'(t);
    if (t[n-1]) x = x - (66'sd1 <<< n);
    return x;
  endfunction

  function automatic void model(input logic [1:0] m, input logic w, input logic f,
                                input logic [127:0] a, input logic [127:0] b,
                                output logic [127:0] r, output logic s);
    int n;
    int base;
    logic signed [65:0] x, y, p, minv;
    logic [127:0] mk;
    n = w ? 32 : 16;
    r = '0;
    s = 1'b0;
    minv = -(66'sd1 <<< (n-1));
    if (m == 2'b11) return;
    if (m == 2'b10) begin
      base = f ? 64/n : 0;
      mk = (128'd1 << (2*n)) - 1;
      for (int k = 0; k < 64/n; k++) begin
        x = lane_val(a, n, base + k);
        y = lane_val(b, n, base + k);
        if (x == minv && y == minv) begin
          p = (66'sd1 <<< (2*n-1)) - 1;
          s = 1'b1;
        end else p = 2 * x * y;
        r = r | ((128'(p) & mk) << (k*2*n));
      end
    end else begin
      mk = (128'd1 << n) - 1;
      for (int k = 0; k < (f ? 128 : 64)/n; k++) begin
        x = lane_val(a, n, k);
        y = lane_val(b, n, k);
        if (x == minv && y == minv) begin
          p = (66'sd1 <<< (n-1)) - 1;
          s = 1'b1;
        end else begin
          p = 2 * x * y;
          if (m == 2'b01) p = p + (66'sd1 <<< (n-1));
          p = p >>> n;
        end
        r = r | ((128'(p) & mk) << (k*n));
      end
    end
  endfunction

  function automatic logic [127:0] put_min(input logic [127:0] v, input int n, input int k);
    logic [127:0] mk;
    mk = ((128'd1 << n) - 1) << (k*n);
    return (v & ~mk) | (128'd1 << (k*n + n - 1));
  endfunction

  task automatic check(input string tag);
    checks++;
    if (res_o !== exp_res || valid_o !== exp_valid || sat_o !== exp_sat) begin
      errors++;
      $display("FAIL %s: res=%h valid=%b sat=%b expected res=%h valid=%b sat=%b",
               tag, res_o, valid_o, sat_o, exp_res, exp_valid, exp_sat);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] m, input logic w, input logic f,
                      input logic [127:0] a, input logic [127:0] b, input logic clr,
                      input string tag);
    logic [127:0] r;
    logic s;
    valid_i = v; mode_i = m; wide_i = w; full_i = f;
    a_i = a; b_i = b; sat_clr_i = clr;
    model(m, w, f, a, b, r, s);
    if (v) exp_res = r;
    exp_valid = v;
    exp_sat = (clr ? 1'b0 : exp_sat) | (v & s);
    @(negedge clk);
    check(tag);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [127:0] a, b;
    rst_ni = 1'b0; valid_i = 1'b0; mode_i = 2'b00; wide_i = 1'b0; full_i = 1'b0;
    a_i = '0; b_i = '0; sat_clr_i = 1'b0;
    exp_res = '0; exp_valid = 1'b0; exp_sat = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check("R10 after release");

    // R1 truncating high half
    step(1, 2'b00, 0, 0, {64'h0, 64'h4000_7FFF_FFFF_0003}, {64'h0, 64'h4000_7FFF_0001_FFFD}, 0, "R1 hi16");
    step(1, 2'b00, 1, 1, rnd128(), rnd128(), 0, "R1 hi32 128b");
    // R2 rounding: 1*0x4000 doubled is 0x8000, rounds up to 1
    step(1, 2'b01, 0, 1, {8{16'h0001}}, {8{16'h4000}}, 0, "R2 rhi16 round up");
    step(1, 2'b01, 1, 0, rnd128(), rnd128(), 0, "R2 rhi32");
    // R3 long, both halves
    step(1, 2'b10, 0, 0, rnd128(), rnd128(), 0, "R3 long16 low half");
    step(1, 2'b10, 1, 1, rnd128(), rnd128(), 0, "R3 long32 high half");
    // R7 upper operand bits ignored in 64-bit high form
    step(1, 2'b00, 0, 0, {64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0}, {64'h8000_8000_8000_8000, 64'h7654_3210_0F0F_F0F0}, 0, "R7 narrow high");
    step(1, 2'b01, 1, 0, {64'h8000_0000_8000_0000, 64'h0}, {64'h8000_0000_8000_0000, 64'h5}, 0, "R7 narrow no clamp");
    // R4/R5 clamp in each form, then sticky hold
    step(1, 2'b00, 0, 1, put_min(128'h0, 16, 6), put_min(128'h0, 16, 6), 0, "R4 hi16 clamp");
    step(1, 2'b00, 0, 0, rnd128(), 128'h0, 0, "R5 sticky holds");
    step(0, 2'b00, 0, 0, 128'h0, 128'h0, 1, "R6 clear");
    step(1, 2'b01, 1, 0, put_min(rnd128(), 32, 1), put_min(rnd128(), 32, 1), 0, "R4 rhi32 clamp");
    step(0, 2'b00, 0, 0, 128'h0, 128'h0, 1, "R6 clear again");
    step(1, 2'b10, 1, 0, put_min(128'h0, 32, 0), put_min(128'h0, 32, 0), 0, "R4 long32 clamp");
    step(1, 2'b10, 0, 1, put_min(128'h0, 16, 5), put_min(128'h0, 16, 5), 1, "R6 set wins over clear");
    step(1, 2'b11, 0, 0, rnd128(), rnd128(), 0, "R8 reserved keeps flag");
    step(0, 2'b00, 0, 0, 128'h0, 128'h0, 1, "R6 clear third");
    step(1, 2'b11, 1, 1, put_min(128'h0, 32, 2), put_min(128'h0, 32, 2), 0, "R8 reserved no set");
    // R9 hold while idle, no set while idle
    step(1, 2'b00, 1, 1, rnd128(), rnd128(), 0, "R9 load");
    step(0, 2'b00, 0, 1, put_min(128'h0, 16, 0), put_min(128'h0, 16, 0), 0, "R9 idle hold");
    step(0, 2'b01, 1, 0, rnd128(), rnd128(), 0, "R9 idle hold 2");
    // R4 clamp in an inactive lane must not set the flag (R7)
    step(1, 2'b00, 0, 0, put_min(128'h0, 16, 7), put_min(128'h0, 16, 7), 0, "R7 inactive lane clamp");
    step(1, 2'b10, 0, 1, put_min(128'h0, 16, 1), put_min(128'h0, 16, 1), 0, "R3 unselected half clamp");

    for (int i = 0; i < 800; i++) begin
      logic [1:0] m;
      logic w, f, v, c;
      int n, k;
      string tag;
      m = 2'($urandom % 4);
      w = 1'($urandom % 2);
      f = 1'($urandom % 2);
      v = ($urandom % 8) != 0;
      c = ($urandom % 16) == 0;
      n = w ? 32 : 16;
      a = rnd128();
      b = rnd128();
      if (($urandom % 4) == 0) begin
        k = int'($urandom % (128/n));
        a = put_min(a, n, k);
        b = put_min(b, n, k);
      end
      case (m)
        2'b00: tag = "R1 random";
        2'b01: tag = "R2 random";
        2'b10: tag = "R3 random";
        default: tag = "R8 random";
      endcase
      step(v, m, w, f, a, b, c, tag);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule